// File: doc/BRIEF.md
# Paged Byte-Write Controller with Busy Polling

This block sits between a simple bus-side request interface and a byte-wide non-volatile storage array, modelled here as a plain memory. A host writes bytes one at a time. The first write opens a page, and the upper address bits of that write fix which page it is. Further writes to the same page are collected in a page buffer, from a single byte up to a full page of 2^PAGE_W bytes. Each accepted write re-arms a load-window timer. When that timer runs out with no new write, the buffered bytes are committed to the array during a programming phase of fixed length.

While programming is in progress, the array cannot be read. Any read during this phase returns a status byte whose marker bit alternates from one read to the next. A host can therefore poll and spot the end of programming early: two reads in a row that return the same value show that the block is idle again. All timer lengths are parameters counted in clock cycles.

Top module: `pwc_page_ctrl`

## Requirements
- R1: After reset, `busy` and `rd_valid` are low.
- R2: A read request sampled at a clock edge while not programming yields `rd_valid` high for exactly the next cycle, with `rdata` equal to the array byte at `addr`.
- R3: A page load of 1 to 2^PAGE_W bytes is committed to the array. The page is `addr[ADDR_W-1:PAGE_W]` of the first write, and the byte within the page is `addr[PAGE_W-1:0]`.
- R4: During a page load, a write whose upper address bits differ from the open page is ignored. It does not restart the load window.
- R5: Programming (`busy` high) begins exactly LOAD_WIN clock edges after the last accepted write. Every accepted write restarts this count.
- R6: During a page load, a write that comes fewer than MIN_GAP clock edges after the previous accepted write is ignored.
- R7: `busy` stays high for exactly PROG_CYC cycles and then falls.
- R8: A read during programming returns a status byte in which every bit is 0 except bit STAT_BIT (default 6). That bit is 1 on the first read of a programming phase and inverts on every later read.
- R9: Writes that arrive during programming are ignored. They do not change the page contents and do not open a new page.
- R10: Bytes of a page that were not written in the current load keep their previous contents. When the same byte is written twice in one load, the later value wins.
- R11: After programming ends, reads return array data and a new write opens a new page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_req | input | 1 | Byte write request, sampled each edge |
| rd_req | input | 1 | Byte read request, sampled each edge |
| addr | input | ADDR_W | Byte address for the read or the write |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data or status byte; valid while `rd_valid` is high |
| rd_valid | output | 1 | Read result valid, one cycle after the request |
| busy | output | 1 | Programming phase in progress |

## Verification
Several properties are checked on every cycle:
- read latency;
- the exact distance from the last accepted write to the start of programming;
- the exact programming length;
- the minimum spacing of accepted writes;
- the alternation of the status bit and the zero value of the other status bits;
- the rule that no write is accepted while busy.

Some behaviours can only be shown by the bench's scenarios, because they depend on what lands in the array: ignored writes to another page, writes during programming, bytes left untouched in a partial page, and repeated writes to one offset. The bench therefore reads the array back after each page and compares the result with its own model. It combines directed corner cases with randomly sized and spaced pages.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOAD = 2'd1,
      PH_PROG = 2'd2
   } pwc_phase_e;

endpackage

// File: rtl/pwc_down_timer.sv
module pwc_down_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             en,
   output logic             last
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (en && (cnt != '0)) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign last = (cnt == CNT_W'(1));

endmodule

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
   parameter int PAGE_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PAGE_W-1:0] wr_off,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr,
   input  logic [PAGE_W-1:0] rd_off,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_vld
);

   localparam int PAGE_BYTES = 1 << PAGE_W;

   logic [DATA_W-1:0]     store [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] vld;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         store[wr_off] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
      end else if (clr) begin
         vld <= '0;
      end else if (wr_en) begin
         vld[wr_off] <= 1'b1;
      end
   end

   assign rd_data = store[rd_off];
   assign rd_vld  = vld[rd_off];

endmodule

// File: rtl/pwc_array.sv
module pwc_array #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         cells[wr_addr] <= wr_data;
      end
      if (rd_en) begin
         rd_data <= cells[rd_addr];
      end
   end

endmodule

// File: rtl/pwc_page_ctrl.sv
module pwc_page_ctrl
   import pwc_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter int DATA_W   = 8,
   parameter int PAGE_W   = 7,
   parameter int LOAD_WIN = 20,
   parameter int PROG_CYC = 200,
   parameter int MIN_GAP  = 3,
   parameter int STAT_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rd_valid,
   output logic              busy
);

   localparam int TAG_W  = ADDR_W - PAGE_W;
   localparam int WIN_W  = $clog2(LOAD_WIN + 1);
   localparam int PROG_W = $clog2(PROG_CYC + 1);

   // elaboration-time parameter checks
   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
      $error("pwc_page_ctrl: PAGE_W must lie in 1..ADDR_W-1");
   end
   if (PROG_CYC < (1 << PAGE_W)) begin : g_bad_prog
      $error("pwc_page_ctrl: PROG_CYC must cover one commit per page byte");
   end
   if (LOAD_WIN < 1 || MIN_GAP < 1) begin : g_bad_win
      $error("pwc_page_ctrl: LOAD_WIN and MIN_GAP must be at least 1");
   end
   if (STAT_BIT >= DATA_W) begin : g_bad_stat
      $error("pwc_page_ctrl: STAT_BIT must index a data bit");
   end

   pwc_phase_e       phase;
   logic [TAG_W-1:0] page_tag;
   logic [PAGE_W:0]  cidx;
   logic             tog;
   logic             rd_stat_q;
   logic             loading;
   logic             in_page;
   logic             gap_ok;
   logic             wr_accept;
   logic             win_last;
   logic             prog_last;
   logic             expire;
   logic             prog_done;
   logic [DATA_W-1:0] buf_data;
   logic             buf_vld;
   logic [DATA_W-1:0] arr_rdata;
   logic [DATA_W-1:0] stat_byte;

   assign loading   = (phase == PH_LOAD);
   assign busy      = (phase == PH_PROG);
   assign in_page   = (addr[ADDR_W-1:PAGE_W] == page_tag);
   assign wr_accept = wr_req && ((phase == PH_IDLE) || (loading && in_page && gap_ok));
   assign expire    = loading && win_last && !wr_accept;
   assign prog_done = busy && prog_last;

   // spacing guard between accepted writes
   if (MIN_GAP > 1) begin : g_gap_cnt
      localparam int GAP_W = $clog2(MIN_GAP);
      logic [GAP_W-1:0] gap_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gap_cnt <= '0;
         end else if (wr_accept) begin
            gap_cnt <= GAP_W'(MIN_GAP - 1);
         end else if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - 1'b1;
         end
      end
      assign gap_ok = (gap_cnt == '0);
   end else begin : g_gap_none
      assign gap_ok = 1'b1;
   end

   pwc_down_timer #(.CNT_W(WIN_W)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_accept),
      .load_val (WIN_W'(LOAD_WIN)),
      .en       (loading),
      .last     (win_last)
   );

   pwc_down_timer #(.CNT_W(PROG_W)) u_prog (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (expire),
      .load_val (PROG_W'(PROG_CYC)),
      .en       (busy),
      .last     (prog_last)
   );

   pwc_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_accept),
      .wr_off  (addr[PAGE_W-1:0]),
      .wr_data (wdata),
      .clr     (prog_done),
      .rd_off  (cidx[PAGE_W-1:0]),
      .rd_data (buf_data),
      .rd_vld  (buf_vld)
   );

   pwc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
      .clk     (clk),
      .wr_en   (busy && !cidx[PAGE_W] && buf_vld),
      .wr_addr ({page_tag, cidx[PAGE_W-1:0]}),
      .wr_data (buf_data),
      .rd_en   (rd_req && !busy),
      .rd_addr (addr),
      .rd_data (arr_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         page_tag  <= '0;
         cidx      <= '0;
         tog       <= 1'b0;
         rd_valid  <= 1'b0;
         rd_stat_q <= 1'b0;
      end else begin
         rd_valid  <= rd_req;
         rd_stat_q <= rd_req && busy;
         unique case (phase)
            PH_IDLE: begin
               if (wr_accept) begin
                  page_tag <= addr[ADDR_W-1:PAGE_W];
                  phase    <= PH_LOAD;
               end
            end
            PH_LOAD: begin
               if (expire) begin
                  phase <= PH_PROG;
                  cidx  <= '0;
                  tog   <= 1'b0;
               end
            end
            PH_PROG: begin
               if (!cidx[PAGE_W]) begin
                  cidx <= cidx + 1'b1;
               end
               if (rd_req) begin
                  tog <= ~tog;
               end
               if (prog_done) begin
                  phase <= PH_IDLE;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign stat_byte = {{(DATA_W-1){1'b0}}, tog} << STAT_BIT;
   assign rdata     = rd_stat_q ? stat_byte : arr_rdata;

endmodule

// File: rtl/pwc_page_ctrl_chk.sv
module pwc_page_ctrl_chk #(
   parameter int DATA_W   = 8,
   parameter int LOAD_WIN = 20,
   parameter int PROG_CYC = 200,
   parameter int MIN_GAP  = 3,
   parameter int STAT_BIT = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rdata,
   input logic              busy,
   input logic              wr_accept,
   input logic              loading
);

   localparam int SINCE_W = $clog2(LOAD_WIN + 2);
   localparam int BCNT_W  = $clog2(PROG_CYC + 1);
   localparam logic [DATA_W-1:0] STAT_MASK = DATA_W'(1) << STAT_BIT;

   logic [SINCE_W-1:0] since;
   logic [BCNT_W-1:0]  bcnt;
   logic               stat_q;
   logic               busy_q;
   logic               pb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since  <= '0;
         bcnt   <= '0;
         stat_q <= 1'b0;
         busy_q <= 1'b0;
         pb     <= 1'b0;
      end else begin
         if (wr_accept) begin
            since <= SINCE_W'(1);
         end else if (since != SINCE_W'(LOAD_WIN + 1)) begin
            since <= since + 1'b1;
         end
         bcnt   <= busy ? bcnt + 1'b1 : '0;
         stat_q <= rd_req && busy;
         busy_q <= busy;
         if (stat_q) begin
            pb <= rdata[STAT_BIT];
         end else if (busy && !busy_q) begin
            pb <= 1'b0;
         end
      end
   end

   a_r2_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);
   a_r5_window: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(since) == SINCE_W'(LOAD_WIN)));
   a_r6_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_accept && loading) |-> (since >= SINCE_W'(MIN_GAP)));
   a_r7_len_max: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (bcnt < BCNT_W'(PROG_CYC)));
   a_r7_len_exact: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(bcnt) == BCNT_W'(PROG_CYC - 1)));
   a_r8_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q |-> (rdata[STAT_BIT] != pb));
   a_r8_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q |-> ((rdata & ~STAT_MASK) == '0));
   a_r9_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !wr_accept);

endmodule

bind pwc_page_ctrl pwc_page_ctrl_chk #(
   .DATA_W   (DATA_W),
   .LOAD_WIN (LOAD_WIN),
   .PROG_CYC (PROG_CYC),
   .MIN_GAP  (MIN_GAP),
   .STAT_BIT (STAT_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_req    (rd_req),
   .rd_valid  (rd_valid),
   .rdata     (rdata),
   .busy      (busy),
   .wr_accept (wr_accept),
   .loading   (loading)
);

// File: tb/pwc_page_ctrl_tb.sv
module pwc_page_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 10;
   localparam int DATA_W     = 8;
   localparam int PAGE_W     = 7;
   localparam int TAG_W      = ADDR_W - PAGE_W;
   localparam int PAGE_BYTES = 1 << PAGE_W;
   localparam int DEPTH      = 1 << ADDR_W;
   localparam int LOAD_WIN   = 20;
   localparam int PROG_CYC   = 200;
   localparam int MIN_GAP    = 3;
   localparam int STAT_BIT   = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_req = 1'b0;
   logic              rd_req = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic              rd_valid;
   logic              busy;

   int checks = 0;
   int fails  = 0;

   logic [DATA_W-1:0] ref_mem   [DEPTH];
   bit                ref_known [DEPTH];
   logic [DATA_W-1:0] pend_d    [PAGE_BYTES];
   bit                pend_v    [PAGE_BYTES];

   always #(CLK_PERIOD/2) clk = ~clk;

   pwc_page_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .LOAD_WIN(LOAD_WIN),
      .PROG_CYC(PROG_CYC), .MIN_GAP(MIN_GAP), .STAT_BIT(STAT_BIT)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .busy(busy)
   );

   function automatic logic [DATA_W-1:0] exp_stat(input int k);
      return (k % 2 == 1) ? (DATA_W'(1) << STAT_BIT) : '0;
   endfunction

   function automatic logic [ADDR_W-1:0] mk_addr(input int tag, input int off);
      return {TAG_W'(tag), PAGE_W'(off)};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr_raw(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      wr_req = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_req = 1'b0;
   endtask

   task automatic wr_acc(input int tag, input int off, input logic [DATA_W-1:0] d);
      wr_raw(mk_addr(tag, off), d);
      pend_d[off] = d;
      pend_v[off] = 1'b1;
   endtask

   task automatic rd_raw(input logic [ADDR_W-1:0] a);
      rd_req = 1'b1; addr = a;
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a);
      rd_raw(a);
      chk(req, 32'(rd_valid), 32'd1);
      if (ref_known[a]) chk(req, 32'(rdata), 32'(ref_mem[a]));
   endtask

   task automatic commit(input int tag);
      for (int i = 0; i < PAGE_BYTES; i++) begin
         if (pend_v[i]) begin
            ref_mem[mk_addr(tag, i)]   = pend_d[i];
            ref_known[mk_addr(tag, i)] = 1'b1;
         end
         pend_v[i] = 1'b0;
      end
   endtask

   // elapsed: negedges already passed since the last accepted write returned
   task automatic finish_page(input int elapsed, input bit poll, input logic [ADDR_W-1:0] pa);
      int used = 0;
      repeat (LOAD_WIN - 1 - elapsed) @(negedge clk);
      chk("R5 busy still low", 32'(busy), 32'd0);
      @(negedge clk);
      chk("R5 busy rises", 32'(busy), 32'd1);
      if (poll) begin
         for (int k = 1; k <= 3; k++) begin
            rd_raw(pa);
            chk("R8 status valid", 32'(rd_valid), 32'd1);
            chk("R8 status byte", 32'(rdata), 32'(exp_stat(k)));
         end
         wr_raw(pa, 8'hEE);  // R9: ignored while programming
         used = 4;
      end
      repeat (PROG_CYC - 1 - used) @(negedge clk);
      chk("R7 busy held", 32'(busy), 32'd1);
      @(negedge clk);
      chk("R7 busy falls", 32'(busy), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < DEPTH; i++) ref_known[i] = 1'b0;
      for (int i = 0; i < PAGE_BYTES; i++) pend_v[i] = 1'b0;

      repeat (3) @(negedge clk);
      chk("R1 busy in reset", 32'(busy), 32'd0);
      chk("R1 rd_valid in reset", 32'(rd_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", 32'(busy), 32'd0);
      chk("R1 rd_valid after reset", 32'(rd_valid), 32'd0);

      // R3 R5 R8 R9: full page at minimum spacing, with polling
      for (int i = 0; i < PAGE_BYTES; i++) begin
         wr_acc(1, i, DATA_W'(i) ^ 8'h5A);
         if (i != PAGE_BYTES - 1) repeat (MIN_GAP - 1) @(negedge clk);
      end
      finish_page(0, 1'b1, mk_addr(1, 5));
      commit(1);
      repeat (LOAD_WIN + 2) @(negedge clk);
      chk("R9 no page opened by busy write", 32'(busy), 32'd0);
      for (int i = 0; i < PAGE_BYTES; i++) rd_chk("R3 R9 full page readback", mk_addr(1, i));
      @(negedge clk);
      chk("R2 rd_valid single cycle", 32'(rd_valid), 32'd0);

      // R3: single-byte page
      wr_acc(2, 7, 8'h77);
      finish_page(0, 1'b0, '0);
      commit(2);
      rd_chk("R3 single byte page", mk_addr(2, 7));

      // R6 R4 R10: too-early write, foreign-page write after last accept
      wr_acc(1, 5, 8'h11);
      wr_raw(mk_addr(1, 6), 8'h22);  // one edge after accept: ignored
      repeat (3) @(negedge clk);
      wr_raw(mk_addr(2, 7), 8'h33);  // other page: ignored, no restart
      finish_page(5, 1'b0, '0);
      commit(1);
      rd_chk("R6 R10 early write ignored", mk_addr(1, 6));
      rd_chk("R4 foreign page untouched", mk_addr(2, 7));
      rd_chk("R10 written byte", mk_addr(1, 5));
      rd_chk("R10 neighbour kept", mk_addr(1, 4));

      // R11 R10 R3: random pages, random offsets and spacing
      for (int p = 0; p < 12; p++) begin
         int tag = $urandom_range(0, (1 << TAG_W) - 1);
         int n   = $urandom_range(1, 10);
         int offs [10];
         for (int j = 0; j < n; j++) begin
            offs[j] = $urandom_range(0, PAGE_BYTES - 1);
            wr_acc(tag, offs[j], DATA_W'($urandom));
            if (j != n - 1) repeat ($urandom_range(MIN_GAP - 1, 10)) @(negedge clk);
         end
         finish_page(0, (p % 3) == 0, mk_addr(tag, 0));
         commit(tag);
         for (int j = 0; j < n; j++) rd_chk("R11 R10 random page readback", mk_addr(tag, offs[j]));
         rd_chk("R10 random unwritten byte", mk_addr(1, $urandom_range(0, PAGE_BYTES - 1)));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule